// File: doc/BRIEF.md
# Self-Calibrating Throttle-to-PWM Mapper

This block converts a radio-control throttle pulse width, already measured elsewhere as an 8-bit count of 10 µs units with a one-cycle valid strobe, into a pulse-width-modulated motor drive. After reset it watches the low-stick pulses and learns a stop position. From that position it derives a run threshold, a brake threshold and a full-throttle point. It then maps every later pulse onto a PWM duty.

The PWM runs from a 200 kHz tick taken from the system clock. The period is normally 60 ticks. At the top of the stick travel the period is stretched to match the full-throttle span, so the output sits at a steady 100%. The full-throttle point follows the stick upward if the transmitter delivers longer pulses than the learned span. A run enable gates sample acceptance. A force-off input kills the drive at once.

Top module: `throttle_pwm_map`

## Requirements
- R1: While uncalibrated, a sample of 0x82 or more is ignored; it neither starts nor breaks the learning count.
- R2: Calibration completes on the tenth consecutive identical accepted sample below 0x82, and `calibrated` rises on that sample's capture edge. A differing sample below 0x82 is discarded and the count restarts from zero. The first sample counts as one of the ten.
- R3: Before calibration `duty_ticks` is 0, `period_ticks` is 60, `pwm_out` and `ft_led` are low, and no sample changes them.
- R4: With learned stop value S, the run threshold is S+2. For a sample p with S+2 < p < full-throttle point, the duty is p−(S+2) ticks and the period is 60 ticks.
- R5: A sample at or below S+2 gives duty 0 with period 60, so `pwm_out` stays low.
- R6: The full-throttle point starts at S+0x3C. A sample at or above it sets the duty and the period both to (full-throttle point − (S+2)), gives a continuously high output, and sets `ft_led` on the capture edge.
- R7: A sample above the current full-throttle point moves that point to the sample minus 1 before the duty is computed. The point never decreases.
- R8: A sample below the full-throttle point clears `ft_led`. A duty that exceeds the period saturates the output high.
- R9: New duty and period values take effect only at a period boundary. In each period `pwm_out` is high from count 0 for `duty_ticks` ticks.
- R10: `force_off` drives `pwm_out` low in the same cycle. From the next period boundary `duty_ticks` reads 0 until release.
- R11: A strobe while `run_en` is low is ignored.
- R12: `brake_zone` is set by an accepted calibrated sample below S−1, with S−1 floored at 0. It is cleared by any other accepted calibrated sample.
- R13: One PWM tick lasts TICK_DIV clock cycles, so a period lasts `period_ticks`×TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_width | input | 8 | Measured throttle pulse, 10 µs units |
| pulse_valid | input | 1 | One-cycle strobe for pulse_width |
| run_en | input | 1 | Sample acceptance enable |
| force_off | input | 1 | Immediate drive kill |
| pwm_out | output | 1 | Motor PWM, active high |
| ft_led | output | 1 | Full-throttle indicator |
| brake_zone | output | 1 | Stick below brake threshold |
| calibrated | output | 1 | Stop position learned |
| duty_ticks | output | 8 | Duty in effect, in ticks |
| period_ticks | output | 8 | Period in effect, in ticks |

## Verification
A wrongly learned stop value moves every later duty by the same offset. It shows in `duty_ticks` one period boundary after the first calibrated sample. A broken learning counter shows at once as `calibrated` rising on the wrong sample. A full-throttle point that is not stretched, or that is stretched wrongly, shows only at the top of the travel: the period reads 60 instead of the span, or a repeated sample no longer lights `ft_led` on its capture edge. Shadow-register faults show in the high-cycle count over one period window.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int PW_W = 8;
  typedef enum logic [1:0] {
    CAL_WAIT   = 2'd0,
    CAL_COUNT  = 2'd1,
    CAL_LOCKED = 2'd2
  } cal_state_e;
endpackage

// File: rtl/tpm_calib.sv
module tpm_calib
  import tpm_pkg::*;
#(
  parameter int           REPEATS = 10,
  parameter logic [7:0]   CEILING = 8'h82
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW_W-1:0] pw,
  input  logic            accept,
  output logic            locked,
  output logic            load_pulse,
  output logic [PW_W-1:0] stop_val
);
  localparam int CNT_W = $clog2(REPEATS + 1);

  cal_state_e            state_q, state_d;
  logic [PW_W-1:0]       ref_q, ref_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  load_q, load_d;
  logic                  low_ok;

  assign low_ok = accept && (pw < CEILING);

  always_comb begin
    state_d = state_q;
    ref_d   = ref_q;
    cnt_d   = cnt_q;
    load_d  = 1'b0;
    unique case (state_q)
      CAL_WAIT: begin
        if (low_ok) begin
          ref_d   = pw;
          cnt_d   = CNT_W'(1);
          state_d = CAL_COUNT;
        end
      end
      CAL_COUNT: begin
        if (low_ok) begin
          if (pw == ref_q) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q + CNT_W'(1) == CNT_W'(REPEATS)) begin
              state_d = CAL_LOCKED;
              load_d  = 1'b1;
            end
          end else begin
            cnt_d   = '0;
            state_d = CAL_WAIT;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_WAIT;
      ref_q   <= '0;
      cnt_q   <= '0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      cnt_q   <= cnt_d;
      load_q  <= load_d;
    end
  end

  assign locked     = (state_q == CAL_LOCKED);
  assign load_pulse = load_q;
  assign stop_val   = ref_q;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(REPEATS));

  p_ignore_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !locked && pw >= CEILING) |=> ($stable(cnt_q) && $stable(ref_q)));
endmodule

// File: rtl/tpm_map.sv
module tpm_map
  import tpm_pkg::*;
#(
  parameter logic [7:0] RUN_OFS   = 8'd2,
  parameter logic [7:0] BRAKE_OFS = 8'd1,
  parameter logic [7:0] FT_OFS    = 8'h3C,
  parameter logic [7:0] NOM_PER   = 8'd60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            locked,
  input  logic            load_pulse,
  input  logic [PW_W-1:0] stop_val,
  input  logic [PW_W-1:0] pw,
  input  logic            accept,
  output logic [PW_W-1:0] duty_req,
  output logic [PW_W-1:0] per_req,
  output logic            ft_led,
  output logic            brake_zone
);
  logic [PW_W-1:0] ft_q, ft_d, duty_q, duty_d, per_q, per_d;
  logic            led_q, led_d, brk_q, brk_d;
  logic [PW_W-1:0] run_th, brake_th, ft_base;
  logic            take;

  assign run_th   = stop_val + RUN_OFS;
  assign brake_th = (stop_val >= BRAKE_OFS) ? (stop_val - BRAKE_OFS) : '0;
  assign ft_base  = load_pulse ? (stop_val + FT_OFS) : ft_q;
  assign take     = locked && accept;

  always_comb begin
    ft_d   = ft_base;
    duty_d = duty_q;
    per_d  = per_q;
    led_d  = led_q;
    brk_d  = brk_q;
    if (take) begin
      if (pw > ft_base) ft_d = pw - 8'd1;
      brk_d = (pw < brake_th);
      if (pw >= ft_base) begin
        duty_d = ft_d - run_th;
        per_d  = ft_d - run_th;
        led_d  = 1'b1;
      end else if (pw > run_th) begin
        duty_d = pw - run_th;
        per_d  = NOM_PER;
        led_d  = 1'b0;
      end else begin
        duty_d = '0;
        per_d  = NOM_PER;
        led_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_q   <= '0;
      duty_q <= '0;
      per_q  <= NOM_PER;
      led_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      ft_q   <= ft_d;
      duty_q <= duty_d;
      per_q  <= per_d;
      led_q  <= led_d;
      brk_q  <= brk_d;
    end
  end

  assign duty_req   = duty_q;
  assign per_req    = per_q;
  assign ft_led     = led_q;
  assign brake_zone = brk_q;

  p_led_needs_cal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ft_led |-> locked);

  p_ft_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> (ft_q >= $past(ft_q)));
endmodule

// File: rtl/tpm_pwm.sv
module tpm_pwm
  import tpm_pkg::*;
#(
  parameter int         TICK_DIV = 625,
  parameter logic [7:0] NOM_PER  = 8'd60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW_W-1:0] duty_req,
  input  logic [PW_W-1:0] per_req,
  input  logic            force_off,
  output logic            pwm_out,
  output logic [PW_W-1:0] duty_now,
  output logic [PW_W-1:0] per_now
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [PW_W-1:0]  cnt_q, cnt_d, duty_q, duty_d, per_q, per_d;
  logic             tick, boundary;

  assign tick     = (div_q == DIV_W'(TICK_DIV - 1));
  assign boundary = tick && ({1'b0, cnt_q} + 9'd1 >= {1'b0, per_q});

  always_comb begin
    div_d  = tick ? '0 : div_q + DIV_W'(1);
    cnt_d  = cnt_q;
    duty_d = duty_q;
    per_d  = per_q;
    if (boundary) begin
      cnt_d  = '0;
      duty_d = force_off ? '0 : duty_req;
      per_d  = per_req;
    end else if (tick) begin
      cnt_d  = cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      duty_q <= '0;
      per_q  <= NOM_PER;
    end else begin
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
      per_q  <= per_d;
    end
  end

  assign pwm_out  = !force_off && (cnt_q < duty_q);
  assign duty_now = duty_q;
  assign per_now  = per_q;

  p_cnt_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_q || per_q == 8'd0 || $changed(per_q));
endmodule

// File: rtl/throttle_pwm_map.sv
module throttle_pwm_map
  import tpm_pkg::*;
#(
  parameter int TICK_DIV = 625
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pulse_width,
  input  logic       pulse_valid,
  input  logic       run_en,
  input  logic       force_off,
  output logic       pwm_out,
  output logic       ft_led,
  output logic       brake_zone,
  output logic       calibrated,
  output logic [7:0] duty_ticks,
  output logic [7:0] period_ticks
);
  localparam logic [7:0] NOM_PER = 8'd60;

  logic            accept, locked, load_pulse;
  logic [PW_W-1:0] stop_val, duty_req, per_req;

  assign accept = pulse_valid && run_en;

  tpm_calib #(.REPEATS(10), .CEILING(8'h82)) u_calib (
    .clk(clk), .rst_n(rst_n), .pw(pulse_width), .accept(accept),
    .locked(locked), .load_pulse(load_pulse), .stop_val(stop_val)
  );

  tpm_map #(.RUN_OFS(8'd2), .BRAKE_OFS(8'd1), .FT_OFS(8'h3C), .NOM_PER(NOM_PER)) u_map (
    .clk(clk), .rst_n(rst_n), .locked(locked), .load_pulse(load_pulse),
    .stop_val(stop_val), .pw(pulse_width), .accept(accept),
    .duty_req(duty_req), .per_req(per_req), .ft_led(ft_led), .brake_zone(brake_zone)
  );

  tpm_pwm #(.TICK_DIV(TICK_DIV), .NOM_PER(NOM_PER)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty_req(duty_req), .per_req(per_req),
    .force_off(force_off), .pwm_out(pwm_out),
    .duty_now(duty_ticks), .per_now(period_ticks)
  );

  assign calibrated = locked;

  p_no_drive_uncal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !calibrated |-> !pwm_out);

  p_force_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> !pwm_out);
endmodule

// File: tb/throttle_pwm_map_tb_top.sv
module throttle_pwm_map_tb_top;
  localparam int TDIV   = 2;
  localparam int SETTLE = 600;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pulse_width;
  logic       pulse_valid, run_en, force_off;
  logic       pwm_out, ft_led, brake_zone, calibrated;
  logic [7:0] duty_ticks, period_ticks;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  throttle_pwm_map #(.TICK_DIV(TDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_width(pulse_width), .pulse_valid(pulse_valid),
    .run_en(run_en), .force_off(force_off), .pwm_out(pwm_out), .ft_led(ft_led),
    .brake_zone(brake_zone), .calibrated(calibrated),
    .duty_ticks(duty_ticks), .period_ticks(period_ticks)
  );

  // {pulse, duty, period, led, brake} for stop value 0x64
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {8'h50, 8'h00, 8'h3C, 8'd0, 8'd1},
    {8'h62, 8'h00, 8'h3C, 8'd0, 8'd1},
    {8'h63, 8'h00, 8'h3C, 8'd0, 8'd0},
    {8'h66, 8'h00, 8'h3C, 8'd0, 8'd0},
    {8'h67, 8'h01, 8'h3C, 8'd0, 8'd0},
    {8'h80, 8'h1A, 8'h3C, 8'd0, 8'd0},
    {8'h9F, 8'h39, 8'h3C, 8'd0, 8'd0},
    {8'hA0, 8'h3A, 8'h3A, 8'd1, 8'd0},
    {8'hB0, 8'h49, 8'h49, 8'd1, 8'd0},
    {8'hAF, 8'h49, 8'h49, 8'd1, 8'd0},
    {8'hAE, 8'h48, 8'h3C, 8'd0, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] pw);
    @(negedge clk);
    pulse_width = pw;
    pulse_valid = 1'b1;
    @(negedge clk);
    pulse_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  // high cycles over one whole period window (R9, R13)
  task automatic measure(input int duty, input int per, input string req);
    int highs = 0;
    int win   = per * TDIV;
    int exp   = ((duty < per) ? duty : per) * TDIV;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    chk(highs == exp, req, highs, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pulse_width = 8'h00; pulse_valid = 1'b0;
    run_en = 1'b1; force_off = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk(!calibrated && !ft_led && !pwm_out, "R3 reset flags", {calibrated, ft_led, pwm_out}, 0);
    chk(duty_ticks == 8'd0 && period_ticks == 8'd60, "R3 reset duty/period",
        {duty_ticks, period_ticks}, {8'd0, 8'd60});

    // R1 high samples ignored during learning
    for (int i = 0; i < 12; i++) send(8'h82);
    chk(!calibrated, "R1 0x82 ignored", calibrated, 0);
    // R2 restart on a differing sample
    for (int i = 0; i < 5; i++) send(8'h64);
    send(8'h65);
    chk(!calibrated, "R2 restart", calibrated, 0);
    for (int i = 0; i < 9; i++) send(8'h64);
    chk(!calibrated, "R2 nine after restart", calibrated, 0);
    settle();
    chk(duty_ticks == 8'd0 && !ft_led, "R3 no drive while learning", duty_ticks, 0);
    send(8'h64);
    chk(calibrated, "R2 tenth sample", calibrated, 1);

    // main mapping table: R4 R5 R6 R7 R8 R12
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][39:32]);
      chk(ft_led == VEC[v][8], "R6/R8 led", ft_led, VEC[v][8]);
      chk(brake_zone == VEC[v][0], "R12 brake", brake_zone, VEC[v][0]);
      settle();
      chk(duty_ticks == VEC[v][31:24], "R4/R5/R6/R7 duty", duty_ticks, VEC[v][31:24]);
      chk(period_ticks == VEC[v][23:16], "R6 period", period_ticks, VEC[v][23:16]);
      measure(int'(VEC[v][31:24]), int'(VEC[v][23:16]), "R9/R13 high count");
    end

    // R11 run enable low: sample dropped
    run_en = 1'b0;
    send(8'hB8);
    chk(!ft_led, "R11 led unchanged", ft_led, 0);
    settle();
    chk(duty_ticks == 8'h48, "R11 duty unchanged", duty_ticks, 8'h48);
    run_en = 1'b1;

    // R10 force off at full throttle
    send(8'hAF);
    settle();
    chk(duty_ticks == 8'h49 && pwm_out, "R6 full before force", duty_ticks, 8'h49);
    @(negedge clk);
    force_off = 1'b1;
    #1;
    chk(!pwm_out, "R10 immediate low", pwm_out, 0);
    settle();
    chk(duty_ticks == 8'd0, "R10 duty held zero", duty_ticks, 0);
    measure(0, int'(period_ticks), "R10 no pulses");
    @(negedge clk);
    force_off = 1'b0;
    settle();
    chk(duty_ticks == 8'h49, "R10 release restores", duty_ticks, 8'h49);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule